// File: doc/BRIEF.md
# Test and Modify Bits Unit

This unit carries out a read-modify-write bit operation on one memory byte, with the accumulator value as the bit mask. A set operation forces to one every memory bit that is one in the mask. A clear operation forces those bits to zero. The unit first tests the original byte against the mask and reports the result in the zero flag. It then writes the modified byte back to the same address.

The surrounding core pulses `start_i` and supplies four inputs with that pulse: the operation select, the address form, the operand address and the accumulator. There are two address forms. The short form uses only the low operand byte and places it in page zero. The long form uses the full 16-bit operand.

The unit drives a synchronous memory port. Read data appears in the cycle after the read strobe. The core's status byte passes through the unit, and the recomputed zero flag is merged into it during the one-cycle `done_o` pulse.

Top module: `tmb_unit`

## Requirements
- R1: During `done_o`, bit 1 of `psr_o` (the zero flag) is 1 when the mask ANDed with the original memory byte is 0x00, and is 0 otherwise.
- R2: The clear operation (`set_op_i`=0) writes back the original byte ANDed with the inverted mask.
- R3: The set operation (`set_op_i`=1) writes back the original byte ORed with the mask.
- R4: Bits 7..2 and bit 0 of `psr_o` always equal those of `psr_i`. While `done_o` is low, `psr_o` equals `psr_i` in full.
- R5: With `long_addr_i`=0, the read and the write both go to address {0x00, `addr_i[7:0]`}, and `addr_i[15:8]` has no effect.
- R6: With `long_addr_i`=1, the read and the write both go to the full `addr_i`.
- R7: The cycle that samples `start_i` counts as cycle 1. The write strobe is high in cycle 5 for the short form and in cycle 6 for the long form, and `done_o` is high in the cycle that follows the write.
- R8: Each operation issues exactly one read and then exactly one write, two cycles later, to the same address. The read and write strobes are never high together.
- R9: `done_o` is high for exactly one cycle per operation.
- R10: `start_i` is ignored from cycle 2 through the write cycle. It is accepted while the unit is idle and in the `done_o` cycle.
- R11: After reset the unit is idle: `done_o`, `mem_rd_o` and `mem_wr_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, one cycle |
| set_op_i | input | 1 | 1 = set mask bits, 0 = clear mask bits |
| long_addr_i | input | 1 | 1 = full 16-bit address, 0 = page-zero address |
| addr_i | input | 16 | Operand address |
| acc_i | input | 8 | Mask (accumulator value) |
| psr_i | input | 8 | Current status byte |
| psr_o | output | 8 | Status byte with the updated zero flag while `done_o` is high |
| mem_addr_o | output | 16 | Memory address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid one cycle after `mem_rd_o` |
| done_o | output | 1 | Completion pulse |

## Verification
The assertions check the following on every cycle:
- the read and write strobes never overlap;
- every write comes two cycles after a read to the same address;
- a short-form read stays in page zero;
- `done_o` always follows a write and lasts one cycle;
- the status bits other than Z always pass through unchanged.

Only the bench scenarios can show the rest. These are the data values the two operations write, the value of the zero flag against the original byte, and the exact cycle numbers of the two address forms. The same holds for the effect of `start_i` pulses issued while an operation is in progress.

// File: rtl/tmb_pkg.sv
package tmb_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned Z_BIT  = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPND,
    ST_OPND_HI,
    ST_READ,
    ST_MOD,
    ST_WRITE,
    ST_DONE
  } tmb_state_e;
endpackage

// File: rtl/tmb_addr_gen.sv
module tmb_addr_gen #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PAGE_W = 8
) (
  input  logic              long_i,
  input  logic [ADDR_W-1:0] opnd_i,
  output logic [ADDR_W-1:0] ea_o
);
  localparam int unsigned HI_W = ADDR_W - PAGE_W;

  always_comb begin
    if (long_i) ea_o = opnd_i;
    else        ea_o = {{HI_W{1'b0}}, opnd_i[PAGE_W-1:0]};
  end
endmodule

// File: rtl/tmb_bit_alu.sv
module tmb_bit_alu #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              set_i,
  input  logic [DATA_W-1:0] mem_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] res_o,
  output logic              zero_o
);
  logic [DATA_W-1:0] hit;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign hit[b]   = mem_i[b] & mask_i[b];
    assign res_o[b] = mask_i[b] ? set_i : mem_i[b];
  end

  assign zero_o = ~|hit;
endmodule

// File: rtl/tmb_seq.sv
module tmb_seq
  import tmb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       long_i,
  output logic       accept_o,
  output logic       rd_o,
  output logic       cap_o,
  output logic       wr_o,
  output logic       done_o
);
  tmb_state_e state_q, state_d;

  assign accept_o = start_i && (state_q == ST_IDLE || state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept_o) state_d = ST_OPND;
      ST_OPND:    state_d = long_i ? ST_OPND_HI : ST_READ;
      ST_OPND_HI: state_d = ST_READ;
      ST_READ:    state_d = ST_MOD;
      ST_MOD:     state_d = ST_WRITE;
      ST_WRITE:   state_d = ST_DONE;
      ST_DONE:    state_d = accept_o ? ST_OPND : ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign rd_o   = (state_q == ST_READ);
  assign cap_o  = (state_q == ST_MOD);
  assign wr_o   = (state_q == ST_WRITE);
  assign done_o = (state_q == ST_DONE);

  assert_seq_order_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> cap_o);
endmodule

// File: rtl/tmb_unit.sv
module tmb_unit
  import tmb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              set_op_i,
  input  logic              long_addr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] psr_i,
  output logic [DATA_W-1:0] psr_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_o
);
  logic              accept, cap;
  logic              set_q, long_q;
  logic [ADDR_W-1:0] ea_d, ea_q;
  logic [DATA_W-1:0] mask_q, orig_q, new_byte;
  logic              zero;

  tmb_addr_gen #(.ADDR_W(ADDR_W), .PAGE_W(8)) u_agen (
    .long_i (long_addr_i),
    .opnd_i (addr_i),
    .ea_o   (ea_d)
  );

  tmb_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .long_i   (long_q),
    .accept_o (accept),
    .rd_o     (mem_rd_o),
    .cap_o    (cap),
    .wr_o     (mem_wr_o),
    .done_o   (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q  <= 1'b0;
      long_q <= 1'b0;
      ea_q   <= '0;
      mask_q <= '0;
      orig_q <= '0;
    end else begin
      if (accept) begin
        set_q  <= set_op_i;
        long_q <= long_addr_i;
        ea_q   <= ea_d;
        mask_q <= acc_i;
      end
      if (cap) orig_q <= mem_rdata_i;
    end
  end

  tmb_bit_alu #(.DATA_W(DATA_W)) u_alu (
    .set_i  (set_q),
    .mem_i  (orig_q),
    .mask_i (mask_q),
    .res_o  (new_byte),
    .zero_o (zero)
  );

  assign mem_addr_o  = (mem_rd_o || mem_wr_o) ? ea_q : '0;
  assign mem_wdata_o = mem_wr_o ? new_byte : '0;

  always_comb begin
    psr_o = psr_i;
    if (done_o) psr_o[Z_BIT] = zero;
  end

  assert_no_rd_wr_overlap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));
  assert_wr_follows_rd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> ($past(mem_rd_o, 2) && mem_addr_o == $past(mem_addr_o, 2)));
  assert_short_page_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && !long_q) |-> (mem_addr_o[ADDR_W-1:8] == '0));
  assert_done_after_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_wr_o));
  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_psr_passthru_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((psr_o ^ psr_i) & ~(DATA_W'(1) << Z_BIT)) == '0);
endmodule

// File: tb/tmb_unit_test.sv
module tmb_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, set_op = 1'b0, long_addr = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  acc = '0, psr_in = '0;
  logic [7:0]  psr_out, wdata, rdata;
  logic [15:0] maddr;
  logic        rd, wr, done;

  int checks = 0, errors = 0;
  logic [7:0] ram [logic [15:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  tmb_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .set_op_i(set_op),
    .long_addr_i(long_addr), .addr_i(addr), .acc_i(acc), .psr_i(psr_in),
    .psr_o(psr_out), .mem_addr_o(maddr), .mem_rd_o(rd), .mem_wr_o(wr),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata), .done_o(done)
  );

  function automatic logic [7:0] peek(logic [15:0] a);
    if (ram.exists(a)) return ram[a];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (rd) rdata <= peek(maddr);
    if (wr) ram[maddr] = wdata;
  end

  function automatic logic [7:0] exp_byte(logic s, logic [7:0] m, logic [7:0] k);
    return s ? (m | k) : (m & ~k);
  endfunction

  function automatic logic [15:0] exp_addr(logic l, logic [15:0] a);
    return l ? a : {8'h00, a[7:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // run one operation; optionally pulse a disturbing start in cycle 3
  task automatic run_op(logic s, logic l, logic [15:0] a, logic [7:0] k,
                        logic [7:0] p, logic disturb);
    logic [15:0] ea = exp_addr(l, a);
    logic [7:0]  orig = peek(ea);
    int rd_n = 0, wr_n = 0, done_n = 0, rd_c = 0, wr_c = 0, done_c = 0;
    logic [15:0] rd_a = '0, wr_a = '0;
    logic [7:0]  wr_d = '0, psr_done = '0;
    int wc = l ? 6 : 5;
    @(negedge clk);
    start = 1'b1; set_op = s; long_addr = l; addr = a; acc = k; psr_in = p;
    for (int c = 2; c <= 10; c++) begin
      @(negedge clk);
      start = 1'b0;
      if (disturb && c == 3) begin
        start = 1'b1; set_op = ~s; long_addr = ~l; addr = ~a; acc = ~k;
      end
      if (rd) begin rd_n++; rd_c = c; rd_a = maddr; end
      if (wr) begin wr_n++; wr_c = c; wr_a = maddr; wr_d = wdata; end
      if (done) begin done_n++; done_c = c; psr_done = psr_out; end
      if (!done && c > wc + 1) check("R4 idle psr", psr_out, p);
    end
    start = 1'b0;
    check("R8 read count", rd_n, 1);
    check("R8 write count", wr_n, 1);
    check("R8 read-to-write spacing", wr_c - rd_c, 2);
    check("R7 write cycle", wr_c, wc);
    check("R7 done cycle", done_c, wc + 1);
    check("R9 done width", done_n, 1);
    if (l) check("R6 long address", wr_a, ea);
    else   check("R5 short address", wr_a, ea);
    check("R8 read address", rd_a, ea);
    if (s) check("R3 set data", wr_d, exp_byte(1'b1, orig, k));
    else   check("R2 clear data", wr_d, exp_byte(1'b0, orig, k));
    check("R1 zero flag", psr_done[1], ((orig & k) == 8'h00));
    check("R4 other bits", psr_done & 8'hFD, p & 8'hFD);
    if (disturb) check("R10 disturb ignored", wr_d, exp_byte(s, orig, k));
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    check("R11 reset done", done, 1'b0);
    check("R11 reset rd", rd, 1'b0);
    check("R11 reset wr", wr, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle after reset", {done, rd, wr}, 3'b000);

    // directed corners
    run_op(1'b0, 1'b0, 16'h0080, 8'h00, 8'hC1, 1'b0); // empty mask: Z=1, byte kept
    run_op(1'b0, 1'b1, 16'h2000, 8'hFF, 8'h3E, 1'b0); // clear all
    run_op(1'b1, 1'b1, 16'h10FF, 8'h80, 8'hFF, 1'b0);
    run_op(1'b1, 1'b0, 16'hAB42, 8'h0F, 8'h00, 1'b0); // R5 high byte ignored
    run_op(1'b0, 1'b0, 16'h0042, 8'hF0, 8'h41, 1'b0); // revisit written byte
    run_op(1'b1, 1'b0, 16'h0077, 8'h3C, 8'h80, 1'b1); // R10
    run_op(1'b0, 1'b1, 16'hFFFF, 8'h55, 8'h02, 1'b1);

    // R10 start accepted in done cycle: back-to-back
    begin
      logic [7:0] o2 = peek(16'h0033);
      int wr_c = 0, n = 0;
      run_op(1'b1, 1'b0, 16'h0011, 8'h01, 8'h00, 1'b0);
      @(negedge clk);
      start = 1'b1; set_op = 1'b1; long_addr = 1'b0; addr = 16'h0033; acc = 8'h81;
      @(negedge clk); start = 1'b0;
      for (int c = 2; c <= 8; c++) begin
        if (c > 2) @(negedge clk);
        if (c == 3 && wr_c == 0) begin
          start = 1'b1; acc = 8'h00; addr = 16'h0034;
        end
        if (wr) begin wr_c = c; n++; end
        if (done && c == 6) begin
          start = 1'b1; set_op = 1'b0; addr = 16'h0033; acc = 8'h81;
        end else if (c != 3) start = 1'b0;
      end
      start = 1'b0;
      check("R10 first write count", n, 1);
      repeat (6) @(negedge clk);
      check("R10 back-to-back data", peek(16'h0033), o2 & 8'h7E);
    end

    for (int i = 0; i < 200; i++) begin
      logic [15:0] a = 16'($urandom);
      logic [7:0]  k = 8'($urandom);
      if (i % 4 == 0) a = {8'($urandom), 8'h00 | 8'($urandom_range(0, 7))};
      run_op(1'($urandom), 1'($urandom), a, (i % 10 == 0) ? 8'h00 : k,
             8'($urandom), (i % 7 == 0));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule